// File: doc/BRIEF.md
# Bridge Power-Up and Hot-Plug Gating Sequencer

This controller brings a display bridge out of power-down and into a usable state. It then guards access to the bridge with the hot-plug-detect line. When a power-on request arrives, it releases the powerdown line and runs reset through two pulses with set spacing. It then waits out a boot period before it reports itself ready. Every delay is a millisecond count multiplied by a cycles-per-millisecond parameter, so a bench can run the whole sequence in a few hundred cycles.

Once ready, a client raises a request. The sequencer samples the hot-plug line on entry and then at a coarse poll interval. It grants the request when it sees the line high, and it signals a timeout if the poll window closes first. The first high sample after each power-on adds a settle delay before the grant, and every power-on re-arms that delay. A power-off request always raises reset one cycle before powerdown. If it arrives while a request is being polled or is granted, it waits until that request ends.

The hot-plug input and all request inputs are taken as synchronous to `clk_i`.

Top module: `bridge_pwr_seq`

## Requirements
- R1: While and after reset, before any request, pd_o=1, rst_o=1, ready_o=0, gnt_o=0 and tmo_o=0.
- R2: A power-on request captured while off drops pd_o at once. rst_o then stays high for RST1_MS*CYC_PER_MS cycles, low for GAP_MS*CYC_PER_MS cycles, high for RST2_MS*CYC_PER_MS cycles, and finally low.
- R3: ready_o rises BOOT_MS*CYC_PER_MS cycles after the final reset release, and stays high only while rst_o and pd_o are both low.
- R4: A request captured while ready starts a poll. hpd_i is sampled in the first poll cycle and then every POLL_MS*CYC_PER_MS cycles. A high level between samples has no effect.
- R5: If no sample is high within TMO_MS*CYC_PER_MS poll cycles, tmo_o pulses for exactly one cycle and ready_o returns without a grant.
- R6: The first high sample after a power-on holds the grant off for SETTLE_MS*CYC_PER_MS cycles. With a one-cycle capture, gnt_o then appears 2+settle cycles after the request. Any later high sample grants on the next cycle, 2 cycles after the request.
- R7: Each new power-on re-arms the settle delay of R6.
- R8: gnt_o, once high, stays high until done_i is seen. Requests made during a grant are ignored.
- R9: On power-off, rst_o is high, with pd_o low, for one cycle before pd_o rises. pd_o is never high while rst_o is low.
- R10: A power-off request that arrives during a poll or a grant is held. gnt_o and pd_o keep their values until done_i, and the power-off sequence of R9 then follows.
- R11: A power-on request is ignored unless the block is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_on_i | input | 1 | Power-on request |
| pwr_off_i | input | 1 | Power-off request |
| hpd_i | input | 1 | Hot-plug-detect level |
| req_i | input | 1 | Client request valid |
| done_i | input | 1 | Client finished with the grant |
| pd_o | output | 1 | Powerdown to bridge, active high |
| rst_o | output | 1 | Reset to bridge, active high |
| ready_o | output | 1 | Powered up and idle, accepts a request |
| gnt_o | output | 1 | Request granted |
| tmo_o | output | 1 | One-cycle pulse: hot-plug poll window expired |

## Verification
The hardest case to reach is a power-off that lands inside an active grant. A settle delay is still armed only when the first request follows a fresh power-on. The stimulus therefore powers on, grants a request, asserts power-off mid-grant and holds it there for several cycles, releases the grant, and then powers on again to show the settle delay re-armed. A hot-plug pulse placed between two poll samples shows that sampling is coarse. A behavioural model compares every output on every cycle.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [3:0] {
    ST_OFF    = 4'd0,
    ST_RST1   = 4'd1,
    ST_GAP    = 4'd2,
    ST_RST2   = 4'd3,
    ST_BOOT   = 4'd4,
    ST_IDLE   = 4'd5,
    ST_WAIT   = 4'd6,
    ST_SETTLE = 4'd7,
    ST_GRANT  = 4'd8,
    ST_PDN    = 4'd9
  } bps_state_e;
endpackage

// File: rtl/bps_timer.sv
module bps_timer #(
  parameter int unsigned CW      = 8,
  parameter int unsigned MAX_CYC = 100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= len_i - CW'(1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - CW'(1);
  end

  assign expired_o = (cnt_q == '0);

  AST_TMR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(MAX_CYC)); // R2
endmodule

// File: rtl/bps_hpd_poll.sv
module bps_hpd_poll #(
  parameter int unsigned POLL_CYC = 20,
  parameter int unsigned TMO_CYC  = 200,
  localparam int unsigned PW = $clog2(POLL_CYC + 1),
  localparam int unsigned TW = $clog2(TMO_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic hpd_i,
  output logic hit_o,
  output logic expire_o
);
  logic [PW-1:0] poll_q;
  logic [TW-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poll_q <= '0;
      win_q  <= '0;
    end else if (!active_i) begin
      poll_q <= '0;
      win_q  <= '0;
    end else begin
      poll_q <= (poll_q == PW'(POLL_CYC - 1)) ? '0 : poll_q + PW'(1);
      if (win_q != TW'(TMO_CYC - 1)) win_q <= win_q + TW'(1);
    end
  end

  assign hit_o    = active_i && (poll_q == '0) && hpd_i;
  assign expire_o = active_i && (win_q == TW'(TMO_CYC - 1)) && !hit_o;

  AST_WIN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q < TW'(TMO_CYC)); // R5
  AST_WIN_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (win_q == '0)); // R4
endmodule

// File: rtl/bridge_pwr_seq.sv
module bridge_pwr_seq
  import bps_pkg::*;
#(
  parameter int unsigned CYC_PER_MS = 100000,
  parameter int unsigned RST1_MS    = 2,
  parameter int unsigned GAP_MS     = 50,
  parameter int unsigned RST2_MS    = 50,
  parameter int unsigned BOOT_MS    = 200,
  parameter int unsigned POLL_MS    = 20,
  parameter int unsigned TMO_MS     = 200,
  parameter int unsigned SETTLE_MS  = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_on_i,
  input  logic pwr_off_i,
  input  logic hpd_i,
  input  logic req_i,
  input  logic done_i,
  output logic pd_o,
  output logic rst_o,
  output logic ready_o,
  output logic gnt_o,
  output logic tmo_o
);
  localparam int unsigned T_RST1   = RST1_MS * CYC_PER_MS;
  localparam int unsigned T_GAP    = GAP_MS * CYC_PER_MS;
  localparam int unsigned T_RST2   = RST2_MS * CYC_PER_MS;
  localparam int unsigned T_BOOT   = BOOT_MS * CYC_PER_MS;
  localparam int unsigned T_POLL   = POLL_MS * CYC_PER_MS;
  localparam int unsigned T_TMO    = TMO_MS * CYC_PER_MS;
  localparam int unsigned T_SETTLE = SETTLE_MS * CYC_PER_MS;
  localparam int unsigned T_MAX_A  = (T_RST1 > T_GAP) ? T_RST1 : T_GAP;
  localparam int unsigned T_MAX_B  = (T_RST2 > T_BOOT) ? T_RST2 : T_BOOT;
  localparam int unsigned T_MAX_C  = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
  localparam int unsigned T_MAX    = (T_MAX_C > T_SETTLE) ? T_MAX_C : T_SETTLE;
  localparam int unsigned CW       = $clog2(T_MAX + 1);

  bps_state_e    state_q, state_d;
  logic          armed_q, pend_q, tmo_q;
  logic          tmr_load, tmr_exp;
  logic [CW-1:0] tmr_len;
  logic          poll_hit, poll_exp;
  logic          go_off;

  assign go_off = pwr_off_i | pend_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:    if (!pwr_off_i && pwr_on_i) state_d = ST_RST1;
      ST_RST1:   if (go_off) state_d = ST_PDN; else if (tmr_exp) state_d = ST_GAP;
      ST_GAP:    if (go_off) state_d = ST_PDN; else if (tmr_exp) state_d = ST_RST2;
      ST_RST2:   if (go_off) state_d = ST_PDN; else if (tmr_exp) state_d = ST_BOOT;
      ST_BOOT:   if (go_off) state_d = ST_PDN; else if (tmr_exp) state_d = ST_IDLE;
      ST_IDLE:   if (go_off) state_d = ST_PDN; else if (req_i) state_d = ST_WAIT;
      ST_WAIT: begin
        if (poll_hit)      state_d = armed_q ? ST_SETTLE : ST_GRANT;
        else if (poll_exp) state_d = ST_IDLE;
      end
      ST_SETTLE: if (tmr_exp) state_d = ST_GRANT;
      ST_GRANT:  if (done_i) state_d = ST_IDLE;
      ST_PDN:    state_d = ST_OFF;
      default:   state_d = ST_OFF;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_RST1:   tmr_len = CW'(T_RST1);
      ST_GAP:    tmr_len = CW'(T_GAP);
      ST_RST2:   tmr_len = CW'(T_RST2);
      ST_BOOT:   tmr_len = CW'(T_BOOT);
      ST_SETTLE: tmr_len = CW'(T_SETTLE);
      default:   tmr_len = CW'(1);
    endcase
  end

  assign tmr_load = (state_d != state_q);

  bps_timer #(.CW(CW), .MAX_CYC(T_MAX)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .len_i     (tmr_len),
    .expired_o (tmr_exp)
  );

  bps_hpd_poll #(.POLL_CYC(T_POLL), .TMO_CYC(T_TMO)) u_poll (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (state_q == ST_WAIT),
    .hpd_i    (hpd_i),
    .hit_o    (poll_hit),
    .expire_o (poll_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tmo_q   <= (state_q == ST_WAIT) && poll_exp;
      // one-shot settle: armed by each power-on, spent by first hit
      if (state_q == ST_OFF && state_d == ST_RST1)         armed_q <= 1'b1;
      else if (state_q == ST_WAIT && state_d == ST_SETTLE) armed_q <= 1'b0;
      if (state_q == ST_OFF || state_d == ST_PDN)          pend_q <= 1'b0;
      else if (pwr_off_i)                                  pend_q <= 1'b1;
    end
  end

  assign pd_o    = (state_q == ST_OFF);
  assign rst_o   = (state_q == ST_OFF) || (state_q == ST_RST1) ||
                   (state_q == ST_RST2) || (state_q == ST_PDN);
  assign ready_o = (state_q == ST_IDLE);
  assign gnt_o   = (state_q == ST_GRANT);
  assign tmo_o   = tmo_q;

  AST_PD_WITH_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_o |-> rst_o); // R9
  AST_PD_AFTER_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_o) |-> $past(rst_o)); // R9
  AST_READY_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!rst_o && !pd_o)); // R3
  AST_TMO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |=> !tmo_o); // R5
  AST_GNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o && !done_i) |=> gnt_o); // R8
  AST_OFF_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o && !done_i) |=> !pd_o); // R10
  AST_ON_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && pwr_on_i && !pwr_off_i && !req_i) |=> ready_o); // R11
endmodule

// File: tb/bridge_pwr_seq_tb.sv
`timescale 1ns/1ps
module bridge_pwr_seq_tb;
  localparam int CPM = 2;
  localparam int L_RST1 = 2 * CPM, L_GAP = 50 * CPM, L_RST2 = 50 * CPM;
  localparam int L_BOOT = 200 * CPM, L_POLL = 20 * CPM, L_TMO = 200 * CPM;
  localparam int L_SETTLE = 50 * CPM;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic pwr_on_i = 0, pwr_off_i = 0, hpd_i = 0, req_i = 0, done_i = 0;
  logic pd_o, rst_o, ready_o, gnt_o, tmo_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string phase = "R1";
  bit cmp_en = 0;

  always #2.5 clk_i = ~clk_i;

  bridge_pwr_seq #(.CYC_PER_MS(CPM)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_on_i(pwr_on_i), .pwr_off_i(pwr_off_i),
    .hpd_i(hpd_i), .req_i(req_i), .done_i(done_i), .pd_o(pd_o), .rst_o(rst_o),
    .ready_o(ready_o), .gnt_o(gnt_o), .tmo_o(tmo_o));

  // behavioural reference: 0 off,1 rst1,2 gap,3 rst2,4 boot,5 idle,6 wait,7 settle,8 grant,9 pdn
  int m_st, m_left, m_el, m_nx;
  bit m_armed, m_pend, m_tmo, m_hit;

  function automatic int len_of(int s);
    case (s)
      1: return L_RST1;
      2: return L_GAP;
      3: return L_RST2;
      4: return L_BOOT;
      default: return L_SETTLE;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_left = 0; m_el = 0; m_armed = 0; m_pend = 0; m_tmo = 0;
    end else begin
      m_nx = m_st; m_tmo = 0;
      case (m_st)
        0: if (!pwr_off_i && pwr_on_i) begin m_nx = 1; m_left = L_RST1; m_armed = 1; end
        1, 2, 3, 4: begin
          if (pwr_off_i || m_pend) m_nx = 9;
          else if (m_left == 1) begin
            m_nx = m_st + 1;
            if (m_nx != 5) m_left = len_of(m_nx);
          end else m_left--;
        end
        5: if (pwr_off_i || m_pend) m_nx = 9; else if (req_i) begin m_nx = 6; m_el = 0; end
        6: begin
          m_hit = ((m_el % L_POLL) == 0) && hpd_i;
          if (m_hit) begin
            if (m_armed) begin m_armed = 0; m_nx = 7; m_left = L_SETTLE; end
            else m_nx = 8;
          end else if (m_el == L_TMO - 1) begin m_nx = 5; m_tmo = 1; end
          else m_el++;
        end
        7: if (m_left == 1) m_nx = 8; else m_left--;
        8: if (done_i) m_nx = 5;
        default: m_nx = 0;
      endcase
      if (m_st == 0 || m_nx == 9) m_pend = 0;
      else if (pwr_off_i) m_pend = 1;
      m_st = m_nx;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (cmp_en) begin
      logic [4:0] exp_v, act_v;
      exp_v = {m_st == 0, m_st inside {0, 1, 3, 9}, m_st == 5, m_st == 8, m_tmo};
      act_v = {pd_o, rst_o, ready_o, gnt_o, tmo_o};
      chk(exp_v == act_v, phase, int'(act_v), int'(exp_v));
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic power_on();
    pwr_on_i = 1; tick(1); pwr_on_i = 0;
    while (!ready_o) tick(1);
  endtask

  // pulse req, return negedges until grant or timeout
  task automatic request(output int n, input bit want_tmo);
    req_i = 1; tick(1); req_i = 0; n = 1;
    while (want_tmo ? !tmo_o : !gnt_o) begin tick(1); n++; end
  endtask

  initial begin
    int n;
    tick(3);
    chk(pd_o && rst_o && !ready_o && !gnt_o && !tmo_o, "R1", {pd_o, rst_o}, 3);
    rst_ni = 1; cmp_en = 1;
    tick(5);
    chk(pd_o && rst_o && !ready_o, "R1", {pd_o, rst_o}, 3);

    phase = "R2";
    pwr_on_i = 1; tick(1); pwr_on_i = 0;
    chk(!pd_o && rst_o, "R2", {pd_o, rst_o}, 1);
    tick(L_RST1);
    chk(!rst_o, "R2", rst_o, 0);
    tick(L_GAP);
    chk(rst_o, "R2", rst_o, 1);
    tick(L_RST2);
    phase = "R3";
    chk(!rst_o && !ready_o, "R3", ready_o, 0);
    tick(L_BOOT);
    chk(ready_o, "R3", ready_o, 1);

    phase = "R11";
    pwr_on_i = 1; tick(1); pwr_on_i = 0; tick(2);
    chk(ready_o && !rst_o, "R11", ready_o, 1);

    phase = "R6";
    hpd_i = 1;
    request(n, 0);
    chk(n == 2 + L_SETTLE, "R6", n, 2 + L_SETTLE);

    phase = "R8";
    req_i = 1; tick(4); req_i = 0;
    chk(gnt_o, "R8", gnt_o, 1);
    done_i = 1; tick(1); done_i = 0;
    chk(ready_o && !gnt_o, "R8", ready_o, 1);

    phase = "R6";
    request(n, 0);
    chk(n == 2, "R6", n, 2);
    done_i = 1; tick(1); done_i = 0;

    phase = "R4";
    hpd_i = 0;
    req_i = 1; tick(1); req_i = 0; n = 1;
    tick(4); n += 4; hpd_i = 1;
    tick(5); n += 5; hpd_i = 0;
    while (n < 60) begin tick(1); n++; end
    chk(!gnt_o, "R4", gnt_o, 0);
    hpd_i = 1;
    while (!gnt_o) begin tick(1); n++; end
    chk(n == 2 + 2 * L_POLL, "R4", n, 2 + 2 * L_POLL);
    done_i = 1; tick(1); done_i = 0;

    phase = "R5";
    hpd_i = 0;
    request(n, 1);
    chk(n == L_TMO + 1, "R5", n, L_TMO + 1);
    tick(1);
    chk(!tmo_o && ready_o && !gnt_o, "R5", tmo_o, 0);

    phase = "R10";
    hpd_i = 1;
    request(n, 0);
    pwr_off_i = 1; tick(1); pwr_off_i = 0;
    tick(8);
    chk(gnt_o && !pd_o, "R10", gnt_o, 1);
    done_i = 1; tick(1); done_i = 0;
    phase = "R9";
    chk(ready_o, "R10", ready_o, 1);
    tick(1);
    chk(rst_o && !pd_o, "R9", {pd_o, rst_o}, 1);
    tick(1);
    chk(pd_o && rst_o, "R9", {pd_o, rst_o}, 3);

    phase = "R7";
    power_on();
    request(n, 0);
    chk(n == 2 + L_SETTLE, "R7", n, 2 + L_SETTLE);
    done_i = 1; tick(1); done_i = 0;

    phase = "R9";
    pwr_off_i = 1; tick(1); pwr_off_i = 0;
    chk(rst_o && !pd_o, "R9", {pd_o, rst_o}, 1);
    tick(1);
    chk(pd_o && rst_o, "R9", {pd_o, rst_o}, 3);
    tick(4);
    finish_run();
  end
endmodule